// File: doc/BRIEF.md
# CEC Frame Receiver

This block listens to a single-wire, open-drain consumer electronics control bus and turns the pulses on it into bytes. All timing is measured in ticks of a count source supplied from outside, so one set of tick-count parameters covers any system clock. A frame opens with a long start pulse and carries one header block and any number of data blocks. Every block has ten bits: eight data bits with the most significant first, an end-of-message bit and an acknowledge bit. Each bit is a falling edge, and the length of the low time that follows gives its value.

The received byte, end-of-message bit and acknowledge bit of the latest block are held in a small buffer. Three status flags report the start bit, the completed byte and the completed block, and each flag has its own interrupt enable. An out-of-tolerance pulse sets a sticky error flag and parks the receiver. Only a drop of the receive enable clears the error. The enable must then stay low across at least one count-source tick before the receiver listens again. An input filter can be switched on to suppress short glitches.

The control FSM has seven states. OFF: receiver disabled. IDLE: waiting for a falling edge. START_LO: timing the low part of the start bit. START_HI: timing the rest of the start bit. BIT_LO: timing a bit's low time. BIT_HI: timing the rest of the bit period. ERR: error parking. Transitions: any state goes to OFF when enable is low. OFF goes to IDLE when enable is high and the tick-qualified low interval has been seen. IDLE goes to START_LO on a falling edge. START_LO goes to START_HI on a rising edge inside the low window. START_HI goes to BIT_LO on a falling edge inside the period window. BIT_LO goes to BIT_HI on a valid rising edge, or to IDLE after the acknowledge bit of a block whose end-of-message bit is 1. BIT_HI goes to BIT_LO on a falling edge inside the bit-period window. Any window violation or timeout in START_LO, START_HI, BIT_LO or BIT_HI goes to ERR.

Top module: `cec_rx_ctrl`

## Requirements
- R1: After reset all flags, the buffer (`rx_data`, `rx_eom`, `rx_ack`) and `irq` are 0. The receiver stays off until `rx_en` has been low during at least one `tick` and is then high.
- R2: A start bit is accepted when its low time is START_LO_T±TOL_T ticks and the time from its falling edge to the next falling edge is START_PER_T±TOL_T ticks. Acceptance sets `flag_start`.
- R3: Bits of a block arrive most significant first. A low time of ONE_LO_T±TOL_T ticks is a 1 and ZERO_LO_T±TOL_T ticks is a 0. After the 8th bit, `rx_data` holds the byte and `flag_byte` is set.
- R4: After the 9th bit, `rx_eom` holds the end-of-message bit. After the 10th bit, `rx_ack` holds the acknowledge bit and `flag_block` is set.
- R5: Blocks keep arriving while the end-of-message bit is 0. After a block whose end-of-message bit is 1, the receiver looks for a new start bit, and a following frame is received.
- R6: A low time or bit period outside its window, or a low or high time running past its window, sets `flag_err`. The receiver then ignores the bus: buffer and other flags stay unchanged.
- R7: `flag_err` stays 1 while `rx_en` is high and becomes 0 when `rx_en` is low.
- R8: Dropping `rx_en` for a stretch that contains no `tick` leaves the receiver off, and frames are ignored. Dropping it across a tick re-arms reception.
- R9: `irq` is 1 exactly when any flag among `flag_start`, `flag_byte` and `flag_block` is 1 with its enable (`irq_start_en`, `irq_byte_en`, `irq_block_en`).
- R10: `irq_ack` clears all three status flags. `flag_clr` bit 0 clears `flag_start`, bit 1 clears `flag_byte` and bit 2 clears `flag_block`.
- R11: With `filt_en` high, a bus level change is taken only after it has been stable for FILT_LEN ticks, so a one-tick glitch has no effect. With `filt_en` low, raw synchronized samples are used, and the same glitch is seen as a bad start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-source tick, one clock wide |
| cec_in | input | 1 | Bus level, asynchronous |
| rx_en | input | 1 | Receive enable |
| filt_en | input | 1 | Glitch filter enable |
| irq_start_en | input | 1 | Interrupt enable for start bit |
| irq_byte_en | input | 1 | Interrupt enable for 8th bit |
| irq_block_en | input | 1 | Interrupt enable for 10th bit |
| irq_ack | input | 1 | Interrupt accepted, clears status flags |
| flag_clr | input | 3 | Per-flag software clear (start, byte, block) |
| rx_data | output | 8 | Data byte of latest block |
| rx_eom | output | 1 | End-of-message bit of latest block |
| rx_ack | output | 1 | Acknowledge bit of latest block |
| flag_start | output | 1 | Start bit received |
| flag_byte | output | 1 | 8th bit received |
| flag_block | output | 1 | 10th bit received |
| flag_err | output | 1 | Sticky receive error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is re-enabling with a disabled interval that contains no count-source tick. The receiver must stay off even though `rx_en` was visibly toggled. The stimulus tracks the phase of its own tick generator and drops `rx_en` for one clock between two ticks. It then sends a valid frame that must be ignored. After that it drops `rx_en` across several ticks and sends a frame that must be received. Timeouts are reached by holding the bus low past the start window with the per-clock comparison held off. Glitches are injected once with the filter off and once with it on, so the same one-tick stimulus is shown to give both outcomes.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_IDLE     = 3'd1,
        ST_START_LO = 3'd2,
        ST_START_HI = 3'd3,
        ST_BIT_LO   = 3'd4,
        ST_BIT_HI   = 3'd5,
        ST_ERR      = 3'd6
    } rx_state_t;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/cec_rx_filter.sv
module cec_rx_filter
    import cec_rx_pkg::*;
#(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic filt_en,
    input  logic cec_in,
    output logic bus_fall,
    output logic bus_rise
);
    localparam int unsigned FW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_q;
    logic                   lvl_d;
    logic [FW-1:0]          fcnt_q;
    logic                   samp;

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            lvl_d  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cec_in};
            lvl_d  <= lvl_q;
        end
    end

    generate
        if (FILT_LEN < 2) begin : g_nofilt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q  <= 1'b1;
                    fcnt_q <= '0;
                end else begin
                    lvl_q  <= samp;
                    fcnt_q <= '0;
                end
            end
        end else begin : g_filt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_q  <= 1'b1;
                    fcnt_q <= '0;
                end else if (!filt_en) begin
                    lvl_q  <= samp;
                    fcnt_q <= '0;
                end else if (samp == lvl_q) begin
                    fcnt_q <= '0;
                end else if (tick) begin
                    if (fcnt_q == FW'(FILT_LEN - 1)) begin
                        lvl_q  <= samp;
                        fcnt_q <= '0;
                    end else begin
                        fcnt_q <= fcnt_q + 1'b1;
                    end
                end
            end
        end
    endgenerate

    assign bus_fall = lvl_d & ~lvl_q;
    assign bus_rise = ~lvl_d & lvl_q;

    // R11: with the filter active the accepted level only moves after a tick
    assert_filter_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) && (FILT_LEN >= 2) && !$stable(lvl_q)) |-> $past(tick));

endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cec_rx_fsm.sv
module cec_rx_fsm
    import cec_rx_pkg::*;
#(
    parameter int unsigned START_LO_T  = 37,
    parameter int unsigned START_PER_T = 45,
    parameter int unsigned BIT_PER_T   = 24,
    parameter int unsigned ONE_LO_T    = 6,
    parameter int unsigned ZERO_LO_T   = 15,
    parameter int unsigned TOL_T       = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 6,
    parameter int unsigned IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_en,
    input  logic             bus_fall,
    input  logic             bus_rise,
    input  logic [CNT_W-1:0] cnt,
    output logic             ev_start,
    output logic             ev_byte,
    output logic             ev_block,
    output logic             ev_err,
    output logic             bit_ok,
    output logic             bit_val,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [CNT_W-1:0] SL_MIN = CNT_W'(START_LO_T - TOL_T);
    localparam logic [CNT_W-1:0] SL_MAX = CNT_W'(START_LO_T + TOL_T);
    localparam logic [CNT_W-1:0] SP_MIN = CNT_W'(START_PER_T - TOL_T);
    localparam logic [CNT_W-1:0] SP_MAX = CNT_W'(START_PER_T + TOL_T);
    localparam logic [CNT_W-1:0] BP_MIN = CNT_W'(BIT_PER_T - TOL_T);
    localparam logic [CNT_W-1:0] BP_MAX = CNT_W'(BIT_PER_T + TOL_T);
    localparam logic [CNT_W-1:0] O_MIN  = CNT_W'(ONE_LO_T - TOL_T);
    localparam logic [CNT_W-1:0] O_MAX  = CNT_W'(ONE_LO_T + TOL_T);
    localparam logic [CNT_W-1:0] Z_MIN  = CNT_W'(ZERO_LO_T - TOL_T);
    localparam logic [CNT_W-1:0] Z_MAX  = CNT_W'(ZERO_LO_T + TOL_T);
    localparam logic [IDX_W-1:0] IDX_BYTE = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_EOM  = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_ACK  = IDX_W'(DATA_W + 1);

    rx_state_t state_q, state_d;
    logic      armed_q;
    logic      eom_q;
    logic      start_lo_ok, start_per_ok, bit_per_ok, is_one, is_zero;

    assign start_lo_ok  = (cnt >= SL_MIN) && (cnt <= SL_MAX);
    assign start_per_ok = (cnt >= SP_MIN) && (cnt <= SP_MAX);
    assign bit_per_ok   = (cnt >= BP_MIN) && (cnt <= BP_MAX);
    assign is_one       = (cnt >= O_MIN)  && (cnt <= O_MAX);
    assign is_zero      = (cnt >= Z_MIN)  && (cnt <= Z_MAX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:      if (armed_q) state_d = ST_IDLE;
                ST_IDLE:     if (bus_fall) state_d = ST_START_LO;
                ST_START_LO: begin
                    if (bus_rise)           state_d = start_lo_ok ? ST_START_HI : ST_ERR;
                    else if (cnt > SL_MAX)  state_d = ST_ERR;
                end
                ST_START_HI: begin
                    if (bus_fall)           state_d = start_per_ok ? ST_BIT_LO : ST_ERR;
                    else if (cnt > SP_MAX)  state_d = ST_ERR;
                end
                ST_BIT_LO: begin
                    if (bus_rise) begin
                        if (!(is_one || is_zero))               state_d = ST_ERR;
                        else if ((bit_idx == IDX_ACK) && eom_q) state_d = ST_IDLE;
                        else                                    state_d = ST_BIT_HI;
                    end else if (cnt > Z_MAX) begin
                        state_d = ST_ERR;
                    end
                end
                ST_BIT_HI: begin
                    if (bus_fall)           state_d = bit_per_ok ? ST_BIT_LO : ST_ERR;
                    else if (cnt > BP_MAX)  state_d = ST_ERR;
                end
                ST_ERR:      state_d = ST_ERR;
                default:     state_d = ST_ERR;
            endcase
        end
    end

    // outputs
    always_comb begin
        ev_start = 1'b0;
        ev_byte  = 1'b0;
        ev_block = 1'b0;
        bit_ok   = 1'b0;
        bit_val  = is_one;
        ev_err   = rx_en && (state_q != ST_ERR) && (state_d == ST_ERR);
        if (rx_en) begin
            unique case (state_q)
                ST_START_HI: ev_start = bus_fall && start_per_ok;
                ST_BIT_LO: begin
                    bit_ok   = bus_rise && (is_one || is_zero);
                    ev_byte  = bit_ok && (bit_idx == IDX_BYTE);
                    ev_block = bit_ok && (bit_idx == IDX_ACK);
                end
                default: ;
            endcase
        end
    end

    // bit position, end-of-message memory, restart arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            eom_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (state_q != ST_OFF)          armed_q <= 1'b0;
            else if (!rx_en && tick)        armed_q <= 1'b1;
            if (ev_start) begin
                bit_idx <= '0;
                eom_q   <= 1'b0;
            end else if (bit_ok) begin
                bit_idx <= (bit_idx == IDX_ACK) ? '0 : bit_idx + 1'b1;
                if (bit_idx == IDX_EOM) eom_q <= bit_val;
            end
        end
    end

    // R6: error parking holds while enabled
    assert_err_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR && rx_en) |=> (state_q == ST_ERR));
    // R8: leaving OFF needs a tick seen while disabled
    assert_restart_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_OFF) |-> $past(armed_q));
    // R4: reception events never coincide
    assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_byte, ev_block, ev_err}));

endmodule

// File: rtl/cec_rx_status.sv
module cec_rx_status #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              ev_start,
    input  logic              ev_byte,
    input  logic              ev_block,
    input  logic              ev_err,
    input  logic              bit_ok,
    input  logic              bit_val,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              irq_ack,
    input  logic [2:0]        flag_clr,
    input  logic [2:0]        irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_eom,
    output logic              rx_ack,
    output logic [2:0]        flags,
    output logic              flag_err,
    output logic              irq
);
    localparam logic [IDX_W-1:0] IDX_EOM = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] IDX_ACK = IDX_W'(DATA_W + 1);

    logic [DATA_W-1:0] shreg_q;
    logic [2:0]        set_v;
    logic [2:0]        clr_v;

    assign set_v = {ev_block, ev_byte, ev_start};
    assign clr_v = flag_clr | {3{irq_ack}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            rx_data <= '0;
            rx_eom  <= 1'b0;
            rx_ack  <= 1'b0;
        end else if (bit_ok) begin
            shreg_q <= {shreg_q[DATA_W-2:0], bit_val};
            if (ev_byte)            rx_data <= {shreg_q[DATA_W-2:0], bit_val};
            if (bit_idx == IDX_EOM) rx_eom  <= bit_val;
            if (bit_idx == IDX_ACK) rx_ack  <= bit_val;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < 3; gi++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            flags[gi] <= 1'b0;
                else if (set_v[gi])    flags[gi] <= 1'b1;
                else if (clr_v[gi])    flags[gi] <= 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_err <= 1'b0;
        else if (!rx_en)  flag_err <= 1'b0;
        else if (ev_err)  flag_err <= 1'b1;
    end

    assign irq = |(flags & irq_en);

    // R7: disabling reception clears the error flag
    assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !flag_err);
    // R7: the error flag is sticky while enabled
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_err && rx_en) |=> flag_err);
    // R10: acceptance clears the start flag unless a new start arrives
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ev_start) |=> !flags[0]);

endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
    import cec_rx_pkg::*;
#(
    parameter int unsigned START_LO_T  = 37,
    parameter int unsigned START_PER_T = 45,
    parameter int unsigned BIT_PER_T   = 24,
    parameter int unsigned ONE_LO_T    = 6,
    parameter int unsigned ZERO_LO_T   = 15,
    parameter int unsigned TOL_T       = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cec_in,
    input  logic       rx_en,
    input  logic       filt_en,
    input  logic       irq_start_en,
    input  logic       irq_byte_en,
    input  logic       irq_block_en,
    input  logic       irq_ack,
    input  logic [2:0] flag_clr,
    output logic [7:0] rx_data,
    output logic       rx_eom,
    output logic       rx_ack,
    output logic       flag_start,
    output logic       flag_byte,
    output logic       flag_block,
    output logic       flag_err,
    output logic       irq
);
    localparam int unsigned DATA_W = 8;
    localparam int unsigned MAX_T  = START_PER_T + TOL_T + 1;
    localparam int unsigned CNT_W  = $clog2(MAX_T + 1);
    localparam int unsigned IDX_W  = $clog2(DATA_W + 2);

    logic             bus_fall, bus_rise;
    logic [CNT_W-1:0] cnt;
    logic             ev_start, ev_byte, ev_block, ev_err;
    logic             bit_ok, bit_val;
    logic [IDX_W-1:0] bit_idx;
    logic [2:0]       flags;

    cec_rx_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .filt_en(filt_en),
        .cec_in(cec_in), .bus_fall(bus_fall), .bus_rise(bus_rise)
    );

    cec_rx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(bus_fall), .cnt(cnt)
    );

    cec_rx_fsm #(
        .START_LO_T(START_LO_T), .START_PER_T(START_PER_T), .BIT_PER_T(BIT_PER_T),
        .ONE_LO_T(ONE_LO_T), .ZERO_LO_T(ZERO_LO_T), .TOL_T(TOL_T),
        .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
        .bus_fall(bus_fall), .bus_rise(bus_rise), .cnt(cnt),
        .ev_start(ev_start), .ev_byte(ev_byte), .ev_block(ev_block), .ev_err(ev_err),
        .bit_ok(bit_ok), .bit_val(bit_val), .bit_idx(bit_idx)
    );

    cec_rx_status #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_status (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .ev_start(ev_start), .ev_byte(ev_byte), .ev_block(ev_block), .ev_err(ev_err),
        .bit_ok(bit_ok), .bit_val(bit_val), .bit_idx(bit_idx),
        .irq_ack(irq_ack), .flag_clr(flag_clr),
        .irq_en({irq_block_en, irq_byte_en, irq_start_en}),
        .rx_data(rx_data), .rx_eom(rx_eom), .rx_ack(rx_ack),
        .flags(flags), .flag_err(flag_err), .irq(irq)
    );

    assign flag_start = flags[0];
    assign flag_byte  = flags[1];
    assign flag_block = flags[2];

endmodule

// File: tb/cec_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module cec_rx_ctrl_tb_top;
    localparam int SLO = 37, SPER = 45, BPER = 24, ONE = 6, ZERO = 15, TOL = 2;
    localparam int MASK = 16;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cec_in = 1'b1;
    logic rx_en = 1'b0, filt_en = 1'b0, irq_ack = 1'b0;
    logic irq_start_en = 1'b1, irq_byte_en = 1'b1, irq_block_en = 1'b1;
    logic [2:0] flag_clr = 3'b000;
    logic [7:0] rx_data;
    logic rx_eom, rx_ack, flag_start, flag_byte, flag_block, flag_err, irq;

    int checks = 0, errors = 0, mask = 0;
    bit hold = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] e_data = '0, m_sh = '0;
    logic e_eom = 0, e_ack = 0, e_fs = 0, e_fb = 0, e_fbl = 0, e_fe = 0;
    bit m_listen = 0, m_active = 0, m_pend = 0, m_eom = 0;
    int m_idx = 0;

    cec_rx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cec_in(cec_in), .rx_en(rx_en),
        .filt_en(filt_en), .irq_start_en(irq_start_en), .irq_byte_en(irq_byte_en),
        .irq_block_en(irq_block_en), .irq_ack(irq_ack), .flag_clr(flag_clr),
        .rx_data(rx_data), .rx_eom(rx_eom), .rx_ack(rx_ack), .flag_start(flag_start),
        .flag_byte(flag_byte), .flag_block(flag_block), .flag_err(flag_err), .irq(irq)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(posedge clk); #3; tick = ~tick;
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !hold && !done) begin
            if (mask > 0) mask = mask - 1;
            else begin
                logic [14:0] act, exp;
                logic e_irq;
                e_irq = (e_fs & irq_start_en) | (e_fb & irq_byte_en) | (e_fbl & irq_block_en);
                act = {rx_data, rx_eom, rx_ack, flag_start, flag_byte, flag_block, flag_err, irq};
                exp = {e_data, e_eom, e_ack, e_fs, e_fb, e_fbl, e_fe, e_irq};
                checks++;
                if (act !== exp) begin
                    errors++;
                    $display("FAIL %s t=%0t actual=%h expected=%h", cur_req, $time, act, exp);
                end
            end
        end
    end

    task automatic wait_ticks(int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic set_bus(logic v);
        cec_in = v; mask = MASK;
    endtask

    task automatic send_start(int lo);
        set_bus(1'b0);
        wait_ticks(lo);
        set_bus(1'b1);
        if (m_listen) begin
            if (lo < SLO - TOL || lo > SLO + TOL) begin
                e_fe = 1; m_listen = 0; // R6
            end else m_pend = 1;
        end
        wait_ticks(SPER - lo);
    endtask

    task automatic model_bit(logic v);
        if (!m_active) return;
        m_sh = {m_sh[6:0], v};
        if (m_idx == 7) begin e_data = m_sh; e_fb = 1; end          // R3
        if (m_idx == 8) begin e_eom = v; m_eom = v; end             // R4
        if (m_idx == 9) begin e_ack = v; e_fbl = 1; if (m_eom) m_active = 0; end
        m_idx = (m_idx == 9) ? 0 : m_idx + 1;
    endtask

    task automatic send_bit(logic v);
        int lo;
        lo = v ? ONE : ZERO;
        set_bus(1'b0);
        if (m_pend) begin m_pend = 0; e_fs = 1; m_active = 1; m_idx = 0; m_eom = 0; end // R2
        wait_ticks(lo);
        set_bus(1'b1);
        model_bit(v);
        wait_ticks(BPER - lo);
    endtask

    task automatic send_bad_bit(int lo);
        set_bus(1'b0);
        if (m_pend) begin m_pend = 0; e_fs = 1; m_active = 1; m_idx = 0; end
        wait_ticks(lo);
        set_bus(1'b1);
        if (m_active) begin e_fe = 1; m_active = 0; m_listen = 0; end
        wait_ticks(BPER - lo);
    endtask

    task automatic send_block(logic [7:0] b, logic eom, logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(eom);
        send_bit(ack);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; e_fs = 0; e_fb = 0; e_fbl = 0; mask = 4;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_clr(logic [2:0] c);
        flag_clr = c; mask = 4;
        if (c[0]) e_fs = 0;
        if (c[1]) e_fb = 0;
        if (c[2]) e_fbl = 0;
        @(negedge clk); flag_clr = 3'b000;
    endtask

    task automatic en_cycle_long();
        rx_en = 1'b0; e_fe = 0; m_listen = 0; m_active = 0; m_pend = 0; mask = MASK;
        wait_ticks(3);
        rx_en = 1'b1; m_listen = 1; mask = MASK;
        wait_ticks(3);
    endtask

    task automatic en_cycle_short();
        while (tick) @(negedge clk);
        rx_en = 1'b0; e_fe = 0; m_listen = 0; m_active = 0; m_pend = 0; mask = MASK;
        @(negedge clk);
        rx_en = 1'b1; mask = MASK;
        wait_ticks(3);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        checks++;
        if ({rx_data, rx_eom, rx_ack, flag_start, flag_byte, flag_block, flag_err, irq} !== 15'd0) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=0",
                {rx_data, rx_eom, rx_ack, flag_start, flag_byte, flag_block, flag_err, irq});
        end
        @(negedge clk);
        // R1: frame before arming is ignored
        cur_req = "R1";
        send_start(SLO); send_block(8'hF0, 1'b1, 1'b1);
        wait_ticks(5);
        en_cycle_long();

        cur_req = "R3";
        send_start(SLO); send_block(8'hA5, 1'b0, 1'b1);
        cur_req = "R4";
        send_block(8'h3C, 1'b1, 1'b0);
        wait_ticks(10);
        cur_req = "R10"; pulse_ack(); wait_ticks(5);

        cur_req = "R9";
        irq_start_en = 1'b0; irq_byte_en = 1'b1; irq_block_en = 1'b0; mask = 4;
        wait_ticks(2);
        send_start(SLO); send_block(8'h81, 1'b1, 1'b1);
        wait_ticks(5);
        cur_req = "R10"; pulse_clr(3'b010); wait_ticks(5);
        cur_req = "R9"; irq_block_en = 1'b1; mask = 4; wait_ticks(5);
        cur_req = "R10"; pulse_clr(3'b101); wait_ticks(5);
        irq_start_en = 1'b1; mask = 4;

        cur_req = "R5";
        send_start(SLO); send_block(8'h12, 1'b0, 1'b0); send_block(8'hFE, 1'b0, 1'b1);
        send_block(8'h6B, 1'b1, 1'b0);
        wait_ticks(8);
        send_start(SLO); send_block(8'h00, 1'b1, 1'b1);
        wait_ticks(8);
        pulse_ack(); wait_ticks(4);

        cur_req = "R6";
        send_start(20); wait_ticks(10);
        cur_req = "R7";
        send_start(SLO); send_block(8'h77, 1'b1, 1'b0);
        wait_ticks(10);

        cur_req = "R8";
        en_cycle_short();
        send_start(SLO); send_block(8'h99, 1'b1, 1'b1);
        wait_ticks(8);
        en_cycle_long();
        send_start(SLO); send_block(8'hC3, 1'b1, 1'b0);
        wait_ticks(8);
        pulse_ack(); wait_ticks(4);

        cur_req = "R6";
        send_start(SLO); send_bit(1'b1); send_bit(1'b0); send_bad_bit(10);
        wait_ticks(10);
        cur_req = "R7"; en_cycle_long();
        cur_req = "R6";
        hold = 1'b1; cec_in = 1'b0;
        wait_ticks(60);
        e_fe = 1; m_listen = 0;
        cec_in = 1'b1; wait_ticks(10);
        hold = 1'b0; mask = 0;
        wait_ticks(5);
        cur_req = "R7"; en_cycle_long();

        cur_req = "R11";
        set_bus(1'b0); wait_ticks(1); set_bus(1'b1);
        e_fe = 1; m_listen = 0;
        wait_ticks(10);
        en_cycle_long();
        filt_en = 1'b1; mask = MASK; wait_ticks(5);
        for (int g = 0; g < 3; g++) begin
            set_bus(1'b0); wait_ticks(1); set_bus(1'b1); wait_ticks(10);
        end
        send_start(SLO); send_block(8'h5A, 1'b1, 1'b0);
        wait_ticks(10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule